// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers the per-channel completion (terminal-count) and fault (error) events of an eight-channel DMA controller into two raw status vectors. It turns them into three active-high level interrupts: one for completions, one for faults, and one that is high when either of the other two is high. The transfer engines pulse one set input per channel and event. Software reads and clears the status through a small register port.

The enable masks have no registers of their own in the address map. Each channel's configuration word supplies them: bit 15 enables that channel's completion interrupt and bit 14 enables its fault interrupt. The block samples these bits into mask registers on every clock edge. Software can read the status three ways: the raw bits, the masked bits, and the masked bits of both kinds ORed together. It clears raw bits by writing ones to the clear addresses. All register reads are combinational from the current address.

Top module: `dma_irq_agg`

## Requirements
- R1: The completion mask bit of channel c is bit 15 of that channel's 32-bit configuration word, and the fault mask bit is bit 14. The masks follow the configuration one clock edge later. No other configuration bit affects them.
- R2: A set pulse on a channel sets that channel's raw bit at the next clock edge. The raw completion vector reads at address 3 and the raw fault vector at address 4, both without masking, in bits [7:0].
- R3: Address 1 reads the raw completion bits ANDed with the completion mask. Address 2 reads the raw fault bits ANDed with the fault mask.
- R4: Address 0 reads the masked completion bits ORed with the masked fault bits.
- R5: A write to address 5 clears every raw completion bit whose write-data bit is one. A write to address 6 does the same for the raw fault bits. All other bits keep their value.
- R6: When a set pulse and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R7: `irqTc` and `irqErr` are registered. Each goes high one edge after its masked vector becomes nonzero and goes low one edge after that vector becomes zero. `irqAny` is high exactly when either of them is high.
- R8: Reset is asynchronous and active low. It clears both raw vectors, both masks and all three interrupt outputs.
- R9: Writes to addresses 0 through 4 and to address 7 change no state. Reads of addresses 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tcSetPulse | input | 8 | Per-channel completion event pulses |
| errSetPulse | input | 8 | Per-channel fault event pulses |
| chanCfg | input | 256 | Configuration words of all channels, channel c in bits [32c+31:32c] |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data; bits [7:0] select the bits to clear |
| regRdData | output | 32 | Read data for the current address |
| irqTc | output | 1 | Masked completion interrupt level |
| irqErr | output | 1 | Masked fault interrupt level |
| irqAny | output | 1 | OR of both interrupt levels |

## Verification
The bench drives a set pulse and a clear of the same bit in one cycle. A design where the clear wins would lose the event and read the bit as zero. It also fills every configuration bit except the two enable bits, which catches a mask taken from the wrong bit position. Writes to read-only addresses must leave the state unchanged, and a reset in the middle of activity must zero the state at once. Every interrupt output is sampled one edge after its masked status changes, so a design that drives the interrupts combinationally, or with an extra stage, disagrees with the bench on timing.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int CFG_TC_BIT  = 15;
  localparam int CFG_ERR_BIT = 14;

  typedef enum logic [2:0] {
    SEL_ANY  = 3'd0,
    SEL_MTC  = 3'd1,
    SEL_MERR = 3'd2,
    SEL_RTC  = 3'd3,
    SEL_RERR = 3'd4,
    SEL_NONE = 3'd7
  } rdSelE;

  typedef struct packed {
    logic  tcClr;
    logic  errClr;
    rdSelE rdSel;
  } ctrlStbT;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStbT           stb
);
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MTC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MERR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RTC  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RERR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTC  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CERR = ADDR_W'(6);

  always_comb begin
    stb.tcClr  = regWrEn && (regAddr == A_CTC);
    stb.errClr = regWrEn && (regAddr == A_CERR);
    case (regAddr)
      A_ANY:   stb.rdSel = SEL_ANY;
      A_MTC:   stb.rdSel = SEL_MTC;
      A_MERR:  stb.rdSel = SEL_MERR;
      A_RTC:   stb.rdSel = SEL_RTC;
      A_RERR:  stb.rdSel = SEL_RERR;
      default: stb.rdSel = SEL_NONE;
    endcase
  end

  // R5/R9: at most one clear strobe per access, never without a write
  always_comb begin
    a_r5_one_clear: assert (!(stb.tcClr && stb.errClr));
    a_r9_no_clear_idle: assert (regWrEn || (!stb.tcClr && !stb.errClr));
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CFG_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStbT                 stb,
  input  logic [NUM_CH-1:0]       tcSet,
  input  logic [NUM_CH-1:0]       errSet,
  input  logic [NUM_CH*CFG_W-1:0] chanCfg,
  input  logic [NUM_CH-1:0]       clrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    irqTc,
  output logic                    irqErr,
  output logic                    irqAny
);
  logic [NUM_CH-1:0] rawTc, rawErr, tcMask, errMask;
  logic [NUM_CH-1:0] tcEnCfg, errEnCfg, tcClrVec, errClrVec;
  logic [NUM_CH-1:0] maskedTc, maskedErr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign tcEnCfg[c]  = chanCfg[c*CFG_W + CFG_TC_BIT];
    assign errEnCfg[c] = chanCfg[c*CFG_W + CFG_ERR_BIT];
  end

  assign tcClrVec  = stb.tcClr  ? clrData : '0;
  assign errClrVec = stb.errClr ? clrData : '0;
  assign maskedTc  = rawTc & tcMask;
  assign maskedErr = rawErr & errMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawTc   <= '0;
      rawErr  <= '0;
      tcMask  <= '0;
      errMask <= '0;
      irqTc   <= 1'b0;
      irqErr  <= 1'b0;
      irqAny  <= 1'b0;
    end else begin
      rawTc   <= (rawTc & ~tcClrVec) | tcSet;
      rawErr  <= (rawErr & ~errClrVec) | errSet;
      tcMask  <= tcEnCfg;
      errMask <= errEnCfg;
      irqTc   <= |maskedTc;
      irqErr  <= |maskedErr;
      irqAny  <= |(maskedTc | maskedErr);
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_ANY:  rdData = DATA_W'(maskedTc | maskedErr);
      SEL_MTC:  rdData = DATA_W'(maskedTc);
      SEL_MERR: rdData = DATA_W'(maskedErr);
      SEL_RTC:  rdData = DATA_W'(rawTc);
      SEL_RERR: rdData = DATA_W'(rawErr);
      default:  rdData = '0;
    endcase
  end

  a_r5_tc_w1c: assert property (@(posedge clk) disable iff (!rstN)
    stb.tcClr |=> ((rawTc & $past(clrData & ~tcSet)) == '0));
  a_r5_err_w1c: assert property (@(posedge clk) disable iff (!rstN)
    stb.errClr |=> ((rawErr & $past(clrData & ~errSet)) == '0));
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|tcSet) |=> ((rawTc & $past(tcSet)) == $past(tcSet)));
  a_r7_tc_level: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqTc == $past(|(rawTc & tcMask))));
  a_r7_any: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqTc || irqErr));
  a_r1_mask_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (errMask == $past(errEnCfg)));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CFG_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       tcSetPulse,
  input  logic [NUM_CH-1:0]       errSetPulse,
  input  logic [NUM_CH*CFG_W-1:0] chanCfg,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData,
  output logic                    irqTc,
  output logic                    irqErr,
  output logic                    irqAny
);
  ctrlStbT stb;

  dma_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .stb    (stb)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH), .CFG_W(CFG_W), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .tcSet  (tcSetPulse),
    .errSet (errSetPulse),
    .chanCfg(chanCfg),
    .clrData(regWrData[NUM_CH-1:0]),
    .rdData (regRdData),
    .irqTc  (irqTc),
    .irqErr (irqErr),
    .irqAny (irqAny)
  );
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb_top;
  localparam int NCH = 8;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] tcSetPulse = '0, errSetPulse = '0;
  logic [NCH*32-1:0] chanCfg = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqTc, irqErr, irqAny;

  int nChecks = 0, nFail = 0;
  logic [NCH-1:0] mTc = '0, mErr = '0, mTcM = '0, mErrM = '0;
  logic mIrqTc = 0, mIrqErr = 0, mIrqAny = 0;

  always #10 clk = ~clk;

  dma_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .tcSetPulse(tcSetPulse), .errSetPulse(errSetPulse),
    .chanCfg(chanCfg), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqTc(irqTc), .irqErr(irqErr), .irqAny(irqAny)
  );

  // fields: tcSet, errSet, tcEn, errEn, wr, addr, data
  localparam logic [43:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00},
    {8'h80, 8'h02, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00},
    {8'h00, 8'h00, 8'h0F, 8'hF0, 1'b0, 3'd0, 8'h00},
    {8'h00, 8'h00, 8'h0F, 8'hF0, 1'b1, 3'd5, 8'h01},
    {8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd6, 8'hFF},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd0, 8'hFF},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd5, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, return at next negedge
  task automatic step(input logic [7:0] tcS, input logic [7:0] errS,
                      input logic [7:0] tcEn, input logic [7:0] errEn,
                      input logic wr, input logic [2:0] addr, input logic [7:0] data,
                      input logic noise);
    logic [7:0] clrT, clrE;
    for (int c = 0; c < NCH; c++) begin
      chanCfg[c*32 +: 32] = noise ? 32'hFFFF_3FFF : 32'h0;
      chanCfg[c*32 + 15] = tcEn[c];
      chanCfg[c*32 + 14] = errEn[c];
    end
    tcSetPulse = tcS; errSetPulse = errS;
    regWrEn = wr; regAddr = addr; regWrData = {24'h0, data};
    @(posedge clk);
    mIrqTc = |(mTc & mTcM);
    mIrqErr = |(mErr & mErrM);
    mIrqAny = mIrqTc | mIrqErr;
    clrT = (wr && addr == 3'd5) ? data : 8'h0;
    clrE = (wr && addr == 3'd6) ? data : 8'h0;
    mTc = (mTc & ~clrT) | tcS;
    mErr = (mErr & ~clrE) | errS;
    mTcM = tcEn; mErrM = errEn;
    @(negedge clk);
    tcSetPulse = '0; errSetPulse = '0; regWrEn = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    regAddr = 3'd3; #1 check({tag, " R2 rawTc"}, regRdData, {24'h0, mTc});
    regAddr = 3'd4; #1 check({tag, " R2 rawErr"}, regRdData, {24'h0, mErr});
    regAddr = 3'd1; #1 check({tag, " R3 maskedTc"}, regRdData, {24'h0, mTc & mTcM});
    regAddr = 3'd2; #1 check({tag, " R3 maskedErr"}, regRdData, {24'h0, mErr & mErrM});
    regAddr = 3'd0; #1 check({tag, " R4 combined"}, regRdData, {24'h0, (mTc & mTcM) | (mErr & mErrM)});
    check({tag, " R7 irqTc"}, {31'h0, irqTc}, {31'h0, mIrqTc});
    check({tag, " R7 irqErr"}, {31'h0, irqErr}, {31'h0, mIrqErr});
    check({tag, " R7 irqAny"}, {31'h0, irqAny}, {31'h0, mIrqAny});
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R8 reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43:36], VEC[i][35:28], VEC[i][27:20], VEC[i][19:12],
           VEC[i][11], VEC[i][10:8], VEC[i][7:0], 1'b0);
      checkAll($sformatf("vec%0d", i));
    end
    // idle cycle so registered irqs settle to the final state
    step(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0);
    checkAll("R7 settle");

    // R6: set and clear of bit 2 in the same cycle, set wins
    step(8'h04, 8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0);
    step(8'h04, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd5, 8'h04, 1'b0);
    regAddr = 3'd3; #1 check("R6 set wins", regRdData, 32'h4);
    checkAll("R6");

    // R1: every other config bit set, enable bits clear -> no mask
    step(8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1);
    step(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1);
    regAddr = 3'd0; #1 check("R1 noise bits masked off", regRdData, 32'h0);
    checkAll("R1");

    // R9: writes to read-only and unused addresses change nothing
    step(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd3, 8'hFF, 1'b0);
    step(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 3'd7, 8'hFF, 1'b0);
    checkAll("R9 ro write");
    regAddr = 3'd7; #1 check("R9 unused read", regRdData, 32'h0);
    regAddr = 3'd5; #1 check("R9 clear addr read", regRdData, 32'h0);

    // R8: asynchronous reset mid-run
    step(8'hA5, 8'h5A, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0);
    step(8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0);
    #2 rstN = 1'b0;
    mTc = '0; mErr = '0; mTcM = '0; mErrM = '0;
    mIrqTc = 0; mIrqErr = 0; mIrqAny = 0;
    #1 checkAll("R8 mid reset");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule